// File: doc/BRIEF.md
# Byte-Wide Peripheral Register Bridge

This block is the slave end of a split request/response on-chip bus with an 8-bit data word, placed in front of a serial communication controller. A master issues one request that carries a command, a byte address and a burst length. The block then runs the whole burst by itself: the address steps by four for every beat. For a write, each beat waits for one byte on a separate write-data handshake. For a read, each beat produces a data byte. Every beat ends with a response code, either null, data-valid or error. The response is held until the master takes it.

Behind the socket sits a register file of 62 byte registers. The bus and the serial controller share it. The bus owns the configuration registers (setup, acceptance filters and outgoing message bytes). The controller owns the status registers, the incoming message bytes and two error counters, and it writes them through a simple core write port. The controller can read any register through a combinational read port. Software finds received data by polling the first status register. A bus read of that register clears it, so each controller event is seen once.

Top module: `perreg_bridge`

## Requirements
- R1: After reset the response is null (2'b00), `req_accept` is high, `wr_accept` is low and every register reads as zero on the core read port.
- R2: Command codes are 3'b001 for write and 3'b010 for read. Any other command value, including idle 3'b000, starts nothing and produces no response.
- R3: A write beat to a bus-owned register stores `wr_data` and answers data-valid (2'b01) in the cycle after the beat is taken. Bus-owned registers are at byte offsets 00h–0Ch (setup), 18h–24h (filters) and 28h–88h (outgoing message). The response data is zero on a write.
- R4: A read beat to any mapped offset (00h–F4h, word-aligned) answers data-valid with the register value in the cycle after the beat is issued. The first read beat is issued in the same cycle that the request is accepted.
- R5: A non-null response and its data stay unchanged until `resp_accept` is sampled high.
- R6: One request starts a burst of `req_blen` beats, and a length of 0 counts as one beat. Beat k uses address base+4k (modulo 256). No new request is accepted until the last response of the burst is taken.
- R7: An offset that is not word-aligned, or that is F8h or above, answers error (2'b11) for both reads and writes. Such a write changes no register.
- R8: A bus write to a controller-owned register answers error and leaves the register unchanged. Controller-owned registers are Status0 at 10h, Status1 at 14h, incoming message bytes at 8Ch–ECh, and the error counters at F0h and F4h.
- R9: The core write port updates only controller-owned registers (word indices 4, 5 and 35–61). It ignores all other indices. `core_rd_data` always shows the register at `core_rd_idx`.
- R10: A bus read of Status0 returns its value and clears it. When the core writes Status0 in the same cycle, the core value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_cmd | input | 3 | Request command |
| req_addr | input | 8 | Burst start byte address |
| req_blen | input | BLW | Burst length in beats (0 means 1) |
| req_accept | output | 1 | Request taken this cycle |
| wr_valid | input | 1 | Write data beat present |
| wr_data | input | DW | Write data byte |
| wr_accept | output | 1 | Write beat taken this cycle |
| resp | output | 2 | Response code |
| resp_rdata | output | DW | Read data for the response |
| resp_accept | input | 1 | Master takes the response |
| core_wr_en | input | 1 | Core register write strobe |
| core_wr_idx | input | 6 | Core write word index |
| core_wr_d | input | DW | Core write data |
| core_rd_idx | input | 6 | Core read word index |
| core_rd_data | output | DW | Core read data |

## Verification
The hardest case to reach is the clash on Status0. The core must write it in exactly the cycle the bus read that clears it is issued. Reaching that needs an idle socket and the read request driven on the same edge as the core write. The bench does both from one sequence step, then checks both the returned old value and the surviving core value. Response holding is reached by a throttled `resp_accept` pattern during bursts. A read burst that starts at F0h steps over the end of the map and mixes data-valid with error beats.

// File: rtl/perreg_bridge.sv
module perreg_bridge #(
  parameter int DW  = 8,
  parameter int BLW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     req_cmd,
  input  logic [7:0]     req_addr,
  input  logic [BLW-1:0] req_blen,
  output logic           req_accept,
  input  logic           wr_valid,
  input  logic [DW-1:0]  wr_data,
  output logic           wr_accept,
  output logic [1:0]     resp,
  output logic [DW-1:0]  resp_rdata,
  input  logic           resp_accept,
  input  logic           core_wr_en,
  input  logic [5:0]     core_wr_idx,
  input  logic [DW-1:0]  core_wr_d,
  input  logic [5:0]     core_rd_idx,
  output logic [DW-1:0]  core_rd_data
);
  localparam logic [2:0] CMD_WR = 3'b001;
  localparam logic [2:0] CMD_RD = 3'b010;
  localparam logic [1:0] R_NULL = 2'b00;
  localparam logic [1:0] R_DVA  = 2'b01;
  localparam logic [1:0] R_ERR  = 2'b11;
  localparam logic [5:0] IDX_ST0 = 6'd4;
  localparam logic [5:0] IDX_ST1 = 6'd5;
  localparam logic [5:0] TX_HI   = 6'd34;
  localparam logic [5:0] RX_LO   = 6'd35;
  localparam logic [5:0] IDX_END = 6'd62;
  localparam logic [BLW-1:0] ONE = {{(BLW-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RESP} st_t;

  st_t            st;
  logic           is_rd;
  logic [7:0]     addr;
  logic [BLW-1:0] left;
  logic [DW-1:0]  mem [64];

  logic [7:0]     beat_addr;
  logic [5:0]     beat_idx;
  logic [BLW-1:0] beats;
  logic map_ok, bus_wr_ok, core_ok, rd_issue, bus_we, rd_clr;

  assign beat_addr = (st == S_IDLE) ? req_addr : (st == S_WR) ? addr : addr + 8'd4;
  assign beat_idx  = beat_addr[7:2];
  assign map_ok    = (beat_addr[1:0] == 2'b00) && (beat_idx < IDX_END);
  assign bus_wr_ok = map_ok && (beat_idx < IDX_ST0 || (beat_idx > IDX_ST1 && beat_idx <= TX_HI));
  assign core_ok   = core_wr_idx == IDX_ST0 || core_wr_idx == IDX_ST1 ||
                     (core_wr_idx >= RX_LO && core_wr_idx < IDX_END);
  assign beats     = (req_blen == '0) ? ONE : req_blen;

  assign rd_issue  = (st == S_IDLE && req_cmd == CMD_RD) ||
                     (st == S_RESP && resp_accept && left != '0 && is_rd);
  assign bus_we    = st == S_WR && wr_valid && bus_wr_ok;
  assign rd_clr    = rd_issue && map_ok && beat_idx == IDX_ST0;

  assign req_accept   = st == S_IDLE;
  assign wr_accept    = st == S_WR;
  assign core_rd_data = mem[core_rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      is_rd      <= 1'b0;
      addr       <= '0;
      left       <= '0;
      resp       <= R_NULL;
      resp_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (req_cmd == CMD_WR || req_cmd == CMD_RD) begin
            addr  <= req_addr;
            left  <= beats - ONE;
            is_rd <= req_cmd == CMD_RD;
            st    <= (req_cmd == CMD_RD) ? S_RESP : S_WR;
          end
        end
        S_WR: begin
          if (wr_valid) begin
            resp       <= bus_wr_ok ? R_DVA : R_ERR;
            resp_rdata <= '0;
            st         <= S_RESP;
          end
        end
        default: begin
          if (resp_accept) begin
            if (left == '0) begin
              resp       <= R_NULL;
              resp_rdata <= '0;
              st         <= S_IDLE;
            end else begin
              left <= left - ONE;
              addr <= addr + 8'd4;
              if (!is_rd) begin
                resp       <= R_NULL;
                resp_rdata <= '0;
                st         <= S_WR;
              end
            end
          end
        end
      endcase
      if (rd_issue) begin
        resp       <= map_ok ? R_DVA : R_ERR;
        resp_rdata <= map_ok ? mem[beat_idx] : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
    end else begin
      if (bus_we) mem[beat_idx] <= wr_data;
      if (rd_clr) mem[IDX_ST0] <= '0;
      if (core_wr_en && core_ok) mem[core_wr_idx] <= core_wr_d;
    end
  end

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp != R_NULL && !resp_accept) |=> (resp == $past(resp) && resp_rdata == $past(resp_rdata))); // R5
  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> resp == R_NULL); // R6
  AST_RD_DVA: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req_cmd == CMD_RD && map_ok) |=> resp == R_DVA); // R4
  AST_WR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && wr_valid && !bus_wr_ok) |=> resp == R_ERR); // R8
  AST_CORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_en && core_wr_idx == IDX_ST0) |=> mem[IDX_ST0] == $past(core_wr_d)); // R10
endmodule

// File: tb/sim_perreg_bridge.sv
module sim_perreg_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] req_cmd = 3'b000;
  logic [7:0] req_addr = '0;
  logic [3:0] req_blen = '0;
  logic req_accept, wr_accept;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] resp;
  logic [7:0] resp_rdata;
  logic resp_accept = 1'b0;
  logic core_wr_en = 1'b0;
  logic [5:0] core_wr_idx = '0;
  logic [7:0] core_wr_d = '0;
  logic [5:0] core_rd_idx = '0;
  logic [7:0] core_rd_data;

  int checks = 0, errors = 0, cyc = 0;
  bit stall = 1'b0, done = 1'b0;
  logic [9:0] exp_q[$];
  string tag_q[$];
  logic [7:0] model [64];

  always #2 clk = ~clk;

  perreg_bridge u0 (.clk, .rst_n, .req_cmd, .req_addr, .req_blen, .req_accept,
    .wr_valid, .wr_data, .wr_accept, .resp, .resp_rdata, .resp_accept,
    .core_wr_en, .core_wr_idx, .core_wr_d, .core_rd_idx, .core_rd_data);

  function automatic bit mapped(input logic [7:0] a);
    return a[1:0] == 2'b00 && a < 8'hF8;
  endfunction
  function automatic bit bus_owned(input logic [7:0] a);
    return mapped(a) && (a <= 8'h0C || (a >= 8'h18 && a <= 8'h88));
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [1:0] h_resp;
  logic [7:0] h_data;
  bit held = 1'b0;
  always @(negedge clk) begin
    cyc++;
    resp_accept = rst_n && (stall ? (cyc % 3 == 0) : 1'b1);
    if (held) check("R5 hold", {h_resp, h_data}, {resp, resp_rdata});
    if (resp != 2'b00 && resp_accept) begin
      if (exp_q.size() == 0) check("R2 unexpected response", {resp, resp_rdata}, 10'h0);
      else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {resp, resp_rdata}, e);
      end
    end
    held = resp != 2'b00 && !resp_accept;
    h_resp = resp;
    h_data = resp_rdata;
  end

  task automatic start_req(input logic [2:0] c, input logic [7:0] a, input logic [3:0] n);
    @(negedge clk);
    while (!req_accept) @(negedge clk);
    req_cmd = c; req_addr = a; req_blen = n;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [3:0] n, input string t);
    int nb;
    nb = (n == 0) ? 1 : int'(n);
    start_req(3'b010, a, n);
    for (int k = 0; k < nb; k++) begin
      logic [7:0] ba;
      ba = a + 8'(4 * k);
      if (mapped(ba)) begin
        exp_q.push_back({2'b01, model[ba[7:2]]});
        if (ba[7:2] == 6'd4) model[4] = 8'h00;
      end else exp_q.push_back({2'b11, 8'h00});
      tag_q.push_back(t);
    end
    @(negedge clk);
    req_cmd = 3'b000;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [3:0] n, input logic [7:0] base, input string t);
    int nb;
    nb = (n == 0) ? 1 : int'(n);
    start_req(3'b001, a, n);
    for (int k = 0; k < nb; k++) begin
      logic [7:0] ba;
      ba = a + 8'(4 * k);
      exp_q.push_back({bus_owned(ba) ? 2'b01 : 2'b11, 8'h00});
      tag_q.push_back(t);
      if (bus_owned(ba)) model[ba[7:2]] = base + 8'(k);
    end
    @(negedge clk);
    req_cmd = 3'b000;
    for (int k = 0; k < nb; k++) begin
      wr_valid = 1'b1;
      wr_data = base + 8'(k);
      while (!wr_accept) @(negedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
    end
  endtask

  task automatic core_write(input logic [5:0] i, input logic [7:0] d);
    @(negedge clk);
    core_wr_en = 1'b1; core_wr_idx = i; core_wr_d = d;
    if (i == 4 || i == 5 || (i >= 35 && i < 62)) model[i] = d;
    @(negedge clk);
    core_wr_en = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input logic [5:0] i, input string t);
    core_rd_idx = i;
    #1;
    check(t, {8'h0, core_rd_data}, {8'h0, model[i]});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 resp", {14'h0, resp}, 16'h0);
    check("R1 req_accept", {15'h0, req_accept}, 16'h1);
    check("R1 wr_accept", {15'h0, wr_accept}, 16'h0);
    peek(6'd0, "R1 reg0"); peek(6'd4, "R1 status0"); peek(6'd61, "R1 rxerr");

    // R2 idle and reserved commands start nothing
    req_cmd = 3'b000; repeat (3) @(negedge clk);
    req_cmd = 3'b111; repeat (3) @(negedge clk);
    req_cmd = 3'b000;
    check("R2 no response", {14'h0, resp}, 16'h0);
    check("R2 still idle", {15'h0, req_accept}, 16'h1);

    // R3 R4 single beats
    bus_write(8'h00, 4'd1, 8'hA5, "R3 setup write");
    drain();
    peek(6'd0, "R3 setup stored");
    bus_read(8'h00, 4'd1, "R4 setup read");
    drain();

    // R6 bursts with R5 stalls
    stall = 1'b1;
    bus_write(8'h28, 4'd4, 8'h10, "R6 tx burst write");
    drain();
    bus_read(8'h28, 4'd4, "R6 tx burst read");
    drain();
    bus_read(8'h18, 4'd0, "R6 zero length");
    drain();
    stall = 1'b0;
    peek(6'd13, "R6 last burst beat");

    // R7 unmapped and misaligned
    bus_read(8'hF8, 4'd1, "R7 read F8");
    bus_read(8'h02, 4'd1, "R7 read misaligned");
    bus_write(8'hFC, 4'd1, 8'h77, "R7 write FC");
    bus_write(8'h01, 4'd1, 8'h66, "R7 write misaligned");
    drain();
    peek(6'd0, "R7 no side effect");

    // R8 writes to core-owned registers
    bus_write(8'h10, 4'd2, 8'h55, "R8 status write");
    bus_write(8'h8C, 4'd1, 8'h44, "R8 rx write");
    bus_write(8'hF0, 4'd2, 8'h33, "R8 err write");
    drain();
    peek(6'd4, "R8 status0 unchanged"); peek(6'd35, "R8 rx unchanged"); peek(6'd60, "R8 err unchanged");

    // R9 core write port
    core_write(6'd35, 8'hC3);
    core_write(6'd60, 8'h09);
    core_write(6'd61, 8'h0B);
    core_write(6'd0, 8'hEE);
    core_write(6'd20, 8'hEE);
    peek(6'd0, "R9 setup ignored"); peek(6'd20, "R9 tx ignored"); peek(6'd35, "R9 rx written");
    bus_read(8'h8C, 4'd1, "R9 rx via bus");
    stall = 1'b1;
    bus_read(8'hF0, 4'd4, "R7 burst off map end");
    drain();
    stall = 1'b0;

    // R10 polling clears Status0, core wins on a clash
    core_write(6'd4, 8'h01);
    bus_read(8'h10, 4'd1, "R10 poll set");
    bus_read(8'h10, 4'd1, "R10 poll cleared");
    drain();
    core_write(6'd4, 8'h02);
    @(negedge clk);
    req_cmd = 3'b010; req_addr = 8'h10; req_blen = 4'd1;
    core_wr_en = 1'b1; core_wr_idx = 6'd4; core_wr_d = 8'h80;
    exp_q.push_back({2'b01, 8'h02}); tag_q.push_back("R10 clash read");
    model[4] = 8'h80;
    @(negedge clk);
    req_cmd = 3'b000; core_wr_en = 1'b0;
    drain();
    peek(6'd4, "R10 core value kept");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule